// File: doc/BRIEF.md
# Serial EEPROM Burst Host Controller

This block drives a four-wire serial EEPROM (select, serial clock, data toward the memory, data back from the memory) from the host side. A user asks for a burst with a single start strobe, a direction, a start address and a word count. The block then runs one complete framed transaction per 16-bit word. Between words it deselects the memory and pulses the clock once, which puts the memory back in its command-wait state.

Read bursts hand back one word per address, each with a one-cycle valid strobe. Write bursts begin with a write-enable frame and end with a write-disable frame. Each word is pulled from the user with a take strobe. After each word is sent, the block polls the memory's data line until it reports ready. The address field is six or eight bits wide, chosen per burst. Every serial clock half-phase lasts one period of an internal divider tick.

If a ready poll runs too long, the burst is aborted and an error flag is raised. The disable frame is still sent in that case.

Top module: `sprom_host`

## Requirements
- R1: While reset is held and afterwards until the first start, eep_cs, eep_sk and eep_do are 0, and busy, done, err, rd_valid and wr_take are 0.
- R2: Every frame begins with exactly one serial clock period with select high and eep_do at 0, followed by the start bit. All bits go out MSB first. Each bit is set up while eep_sk is low and held while eep_sk is high.
- R3: A read frame sends 1,1,0 and then the address. The block then clocks 17 bits, samples eep_di at the end of each low half-phase, drops the first sample, and presents the remaining 16 (first is bit 15) on rd_data with rd_valid high for one cycle.
- R4: A burst of count words covers the addresses start, start+1, …, one word per frame. The address wraps to 0 within the selected width.
- R5: Between any two frames, eep_cs is low and eep_sk makes exactly one low-high-low pulse.
- R6: With addr8=0 the address field is 6 bits and the upper two bits of addr are ignored. With addr8=1 it is 8 bits. The choice is captured at start.
- R7: A write burst first sends an enable frame of 1,0,0,1,1 followed by zeros, and finally a disable frame of 1,0,0,0,0 followed by zeros. Each of these frames is 3+width bits long counting from the start bit (9 or 11).
- R8: Each word write sends 1,0,1, the address, then the 16 bits of wr_data MSB first. wr_data is captured in the cycle before wr_take pulses high for one cycle, once per word.
- R9: After a word's data, select is dropped for one half-phase and raised again. The block then clocks single bits until eep_di samples 1, and only then moves to the next frame.
- R10: If POLL_MAX poll clocks pass without ready, err is set, the remaining words are skipped, and the disable frame is still sent before done. err clears at the next accepted start.
- R11: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse in the cycle busy falls. A start seen while busy has no effect.
- R12: A start with count 0 produces no serial activity and gives done two cycles later.
- R13: The serial clock changes only on a divider tick. Each high half-phase lasts exactly DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Burst request strobe, accepted only when idle |
| wr_mode | input | 1 | 1 = write burst, 0 = read burst |
| addr8 | input | 1 | 1 = 8-bit address field, 0 = 6-bit |
| addr | input | 8 | First word address |
| count | input | CNT_W | Number of words in the burst |
| wr_data | input | 16 | Word to write, captured once per word |
| wr_take | output | 1 | One-cycle pulse after wr_data was captured |
| rd_data | output | 16 | Word read from the memory |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst end |
| err | output | 1 | Ready-poll timeout in the last burst |
| eep_cs | output | 1 | Memory select |
| eep_sk | output | 1 | Serial clock |
| eep_do | output | 1 | Serial data toward the memory |
| eep_di | input | 1 | Serial data from the memory |

## Verification
The bench pairs the host with a behavioural memory model. The model decodes frames, counts select-period bits and deselect pulses, and measures frame lengths. The corner cases covered are:
- Address wrap at both widths. A host that carries into the upper bits would read the wrong word.
- A 6-bit burst with high address bits set. A host that does not mask them would shift the opcode.
- The enable/disable frame length at both widths. A wrong length leaves the memory write-protected or mis-decodes the frame.
- A memory that never reports ready, to check that the disable frame still goes out and that later words are not taken.
- Zero-count bursts and starts that arrive mid-burst. A careless host would emit stray frames or restart.

// File: rtl/sprom_pkg.sv
// Package: shared constants and types for the serial EEPROM host.
// Assumes a memory word of 16 bits and an address field of at most 8 bits.
package sprom_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int VEC_W  = 32;                 // longest frame is 28 bits
    localparam int IDX_W  = $clog2(VEC_W);

    typedef enum logic [3:0] {
        S_IDLE, S_EWEN, S_RCMD, S_RDATA, S_WCMD, S_WDROP,
        S_WPOLL, S_EWDS, S_DSEL, S_DTAIL, S_FIN
    } st_t;
endpackage

// File: rtl/sprom_tick.sv
// Module: divider producing one tick every DIV clock cycles while run is high.
// Assumes DIV >= 1; the counter restarts whenever run is low.
module sprom_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    // Count cycles between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + CW'(1);
    end

    generate
        if (DIV > 1) begin : g_gap
            a_r13_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sprom_bitio.sv
// Module: serial bit engine. A load gives it a right-aligned vector and a length.
// It sends bits MSB first: each bit is driven with sk low for one tick period, then
// sk high for one tick period. Data in is sampled at the end of each low half.
// Assumes the caller loads only while the engine is idle.
module sprom_bitio
    import sprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld,
    input  logic [VEC_W-1:0]  vec,
    input  logic [IDX_W-1:0]  len,
    input  logic              di,
    output logic              sk,
    output logic              dout,
    output logic              fin,
    output logic [WORD_W-1:0] rx
);
    logic             act_q, half_q;
    logic [IDX_W-1:0] idx_q;
    logic [VEC_W-1:0] vec_q;

    assign sk   = act_q && half_q;
    assign dout = act_q && vec_q[idx_q];
    assign fin  = act_q && half_q && tick && (idx_q == '0);

    // Step through half-phases and bit positions on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            half_q <= 1'b0;
            idx_q  <= '0;
            vec_q  <= '0;
        end else if (ld) begin
            act_q  <= 1'b1;
            half_q <= 1'b0;
            idx_q  <= len - IDX_W'(1);
            vec_q  <= vec;
        end else if (act_q && tick) begin
            half_q <= !half_q;
            if (half_q) begin
                if (idx_q == '0) act_q <= 1'b0;
                else             idx_q <= idx_q - IDX_W'(1);
            end
        end
    end

    // Capture data in at the end of each low half-phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                         rx <= '0;
        else if (act_q && !half_q && tick)  rx <= {rx[WORD_W-2:0], di};
    end

    a_r13_sk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sk));
    a_r2_do_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        sk |-> $stable(dout));
endmodule

// File: rtl/sprom_host.sv
// Module: top-level burst sequencer for a serial EEPROM.
// Runs one framed transaction per word, deselects between frames, brackets
// writes with enable/disable frames and polls ready after each written word.
// Assumes the memory shifts on the rising serial clock edge and reports
// ready as a 1 on its data line while selected.
module sprom_host
    import sprom_pkg::*;
#(
    parameter int DIV      = 8,
    parameter int CNT_W    = 8,
    parameter int POLL_MAX = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_mode,
    input  logic              addr8,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_take,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              eep_cs,
    output logic              eep_sk,
    output logic              eep_do,
    input  logic              eep_di
);
    localparam int PW = $clog2(POLL_MAX + 1);

    st_t               st_q, ret_q;
    logic              pend_q, wide_q, wmode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [PW-1:0]     poll_q;

    logic              tick, ld, fin;
    logic [VEC_W-1:0]  vec;
    logic [IDX_W-1:0]  len;
    logic [IDX_W-1:0]  aw;
    logic [ADDR_W-1:0] amask;
    logic [WORD_W-1:0] rx;

    assign busy  = (st_q != S_IDLE);
    assign aw    = wide_q ? IDX_W'(8) : IDX_W'(6);
    assign amask = addr8 ? 8'hFF : 8'h3F;

    sprom_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    sprom_bitio u_bits (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .vec(vec), .len(len),
        .di(eep_di), .sk(eep_sk), .dout(eep_do), .fin(fin), .rx(rx)
    );

    // Select is high in every state that carries a framed command.
    assign eep_cs = (st_q == S_EWEN) || (st_q == S_RCMD) || (st_q == S_RDATA) ||
                    (st_q == S_WCMD) || (st_q == S_WPOLL) || (st_q == S_EWDS);

    // Choose the bit vector and length for the state's frame; a leading 0 is the select period.
    always_comb begin
        vec = '0;
        len = IDX_W'(1);
        ld  = 1'b0;
        unique case (st_q)
            S_EWEN:  begin vec = VEC_W'(6'b010011) << (aw - IDX_W'(2)); len = aw + IDX_W'(4); ld = pend_q; end
            S_EWDS:  begin vec = VEC_W'(6'b010000) << (aw - IDX_W'(2)); len = aw + IDX_W'(4); ld = pend_q; end
            S_RCMD:  begin vec = (VEC_W'(4'b0110) << aw) | VEC_W'(addr_q); len = aw + IDX_W'(4); ld = pend_q; end
            S_RDATA: begin len = IDX_W'(17); ld = pend_q; end
            S_WCMD:  begin
                vec = (((VEC_W'(4'b0101) << aw) | VEC_W'(addr_q)) << WORD_W) | VEC_W'(wr_data);
                len = aw + IDX_W'(20);
                ld  = pend_q;
            end
            S_WPOLL: ld = pend_q;
            S_DSEL:  ld = pend_q;
            default: ld = 1'b0;
        endcase
    end

    // Burst sequencer: accepts requests and walks the frames of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            ret_q    <= S_IDLE;
            pend_q   <= 1'b0;
            wide_q   <= 1'b0;
            wmode_q  <= 1'b0;
            addr_q   <= '0;
            left_q   <= '0;
            poll_q   <= '0;
            err      <= 1'b0;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            wr_take  <= 1'b0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            wr_take  <= ld && (st_q == S_WCMD);
            if (ld) pend_q <= 1'b0;
            unique case (st_q)
                S_IDLE: if (start) begin
                    err     <= 1'b0;
                    wide_q  <= addr8;
                    wmode_q <= wr_mode;
                    addr_q  <= addr & amask;
                    left_q  <= count;
                    pend_q  <= 1'b1;
                    if (count == '0) st_q <= S_FIN;
                    else             st_q <= wr_mode ? S_EWEN : S_RCMD;
                end
                S_EWEN: if (fin) begin
                    st_q <= S_DSEL; ret_q <= S_WCMD; pend_q <= 1'b1;
                end
                S_RCMD: if (fin) begin
                    st_q <= S_RDATA; pend_q <= 1'b1;
                end
                S_RDATA: if (fin) begin
                    rd_data  <= rx;
                    rd_valid <= 1'b1;
                    left_q   <= left_q - CNT_W'(1);
                    addr_q   <= (addr_q + ADDR_W'(1)) & (wide_q ? 8'hFF : 8'h3F);
                    ret_q    <= (left_q == CNT_W'(1)) ? S_FIN : S_RCMD;
                    st_q     <= S_DSEL;
                    pend_q   <= 1'b1;
                end
                S_WCMD: if (fin) begin
                    st_q <= S_WDROP; poll_q <= '0;
                end
                S_WDROP: if (tick) begin
                    st_q <= S_WPOLL; pend_q <= 1'b1;
                end
                S_WPOLL: if (fin) begin
                    if (rx[0]) begin
                        left_q <= left_q - CNT_W'(1);
                        addr_q <= (addr_q + ADDR_W'(1)) & (wide_q ? 8'hFF : 8'h3F);
                        ret_q  <= (left_q == CNT_W'(1)) ? S_EWDS : S_WCMD;
                        st_q   <= S_DSEL;
                    end else if (poll_q == PW'(POLL_MAX - 1)) begin
                        err   <= 1'b1;
                        ret_q <= S_EWDS;
                        st_q  <= S_DSEL;
                    end else begin
                        poll_q <= poll_q + PW'(1);
                    end
                    pend_q <= 1'b1;
                end
                S_EWDS: if (fin) begin
                    st_q <= S_DSEL; ret_q <= S_FIN; pend_q <= 1'b1;
                end
                S_DSEL: if (fin) st_q <= S_DTAIL;
                S_DTAIL: if (tick) begin
                    st_q <= ret_q; pend_q <= 1'b1;
                end
                S_FIN: begin
                    st_q <= S_IDLE; done <= 1'b1;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    a_r11_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r3_valid_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && !wmode_q));
    a_r8_take_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (busy && wmode_q));
    a_r10_err_rise_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> wmode_q);
    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> busy);
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!eep_sk && !eep_cs));
endmodule

// File: tb/sprom_host_bench.sv
// Bench: host controller against a behavioural serial EEPROM model.
module sprom_host_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int POLL_MAX   = 12;

    // Read table: {addr8, start address, count}
    localparam logic [16:0] RTAB [6] = '{
        {1'b0, 8'd5,   8'd3}, {1'b1, 8'd200, 8'd2}, {1'b0, 8'd62,  8'd3},
        {1'b1, 8'd254, 8'd3}, {1'b0, 8'h45,  8'd2}, {1'b1, 8'd0,   8'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, wr_mode = 1'b0, addr8 = 1'b0;
    logic [7:0] addr = '0, count = '0;
    logic [15:0] wr_data, rd_data;
    logic wr_take, rd_valid, busy, done, err, eep_cs, eep_sk, eep_do, eep_di;

    always #(CLK_PERIOD/2) clk = !clk;

    sprom_host #(.DIV(DIV), .CNT_W(8), .POLL_MAX(POLL_MAX)) u_sprom_host (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode), .addr8(addr8),
        .addr(addr), .count(count), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .err(err),
        .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_do(eep_do), .eep_di(eep_di)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    bit wd = 1'b0;

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 16'h1357) ^ 16'hA5C3;
    endfunction

    // ---------------- memory model ----------------
    logic [15:0] mem [256];
    logic [23:0] msh;
    logic [15:0] wd_m;
    logic [7:0]  rd_a, wa;
    logic        rd_bit = 1'b0, stuck = 1'b0, we = 1'b0;
    int mst = 0, mnb = 0, mfb = 0, lead0 = 0, rd_k = 0, kind = 0, wbusy = 0;
    int aw_m = 6, op_m = 0, a_m = 0;
    int ewen_len = 0, ewds_len = 0, ewen_cnt = 0, bad_lead = 0, desel = 0, frames = 0;

    assign eep_di = eep_cs && ((mst == 3) ? rd_bit : (wbusy == 0 && !stuck));

    always @(posedge eep_cs) begin
        lead0 = 0; mst = 0; mfb = 0; kind = 0;
    end
    always @(negedge eep_cs) begin
        if (kind == 1) ewen_len = mfb;
        if (kind == 2) ewds_len = mfb;
        if (mfb > 0) frames++;
        mst = 0; kind = 0;
    end
    always @(posedge eep_sk) begin
        if (wbusy > 0) wbusy--;
        if (!eep_cs) desel++;
        else begin
            case (mst)
                0: if (eep_do) begin
                       if (lead0 != 1) bad_lead++;
                       mst = 1; mnb = 0; msh = '0; mfb = 1;
                   end else lead0++;
                1: begin
                    mfb++; msh = {msh[22:0], eep_do}; mnb++;
                    if (mnb == 2 + aw_m) begin
                        op_m = int'((msh >> aw_m) & 24'd3);
                        a_m  = int'(msh & ((24'd1 << aw_m) - 24'd1));
                        case (op_m)
                            2: begin mst = 3; rd_a = 8'(a_m); rd_bit = 1'b0; rd_k = 0; kind = 3; end
                            1: begin mst = 2; mnb = 0; wa = 8'(a_m); kind = 4; end
                            0: begin
                                mst = 5;
                                if (((a_m >> (aw_m - 2)) & 3) == 3) begin we = 1'b1; kind = 1; ewen_cnt++; end
                                else if (((a_m >> (aw_m - 2)) & 3) == 0) begin we = 1'b0; kind = 2; end
                            end
                            default: mst = 5;
                        endcase
                    end
                end
                2: begin
                    mfb++; wd_m = {wd_m[14:0], eep_do}; mnb++;
                    if (mnb == 16) begin
                        if (we) mem[wa] = wd_m;
                        wbusy = 5; mst = 5;
                    end
                end
                3: begin
                    mfb++;
                    rd_bit = (rd_k < 16) ? mem[rd_a][15 - rd_k] : 1'b0;
                    rd_k++;
                end
                default: mfb++;
            endcase
        end
    end

    // ---------------- output monitors ----------------
    logic [15:0] rd_got [16];
    logic [15:0] wtab [8];
    int nrd = 0, ndone = 0, ntake = 0, widx = 0, skrun = 0, sk_bad = 0;
    assign wr_data = wtab[widx[2:0]];

    always @(negedge clk) begin
        if (rd_valid) begin
            if (nrd < 16) rd_got[nrd] = rd_data;
            nrd++;
        end
        if (done) ndone++;
        if (wr_take) begin ntake++; widx++; end
        if (eep_sk) skrun++;
        else if (skrun > 0) begin
            if (skrun != DIV) sk_bad++;
            skrun = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd) begin
            wd = 1'b1; nchk++; nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic burst(input logic wm, input logic w8, input logic [7:0] a, input logic [7:0] c);
        @(negedge clk);
        wr_mode = wm; addr8 = w8; addr = a; count = c; start = 1'b1;
        nrd = 0; ndone = 0; ntake = 0; widx = 0; aw_m = w8 ? 8 : 6;
        @(negedge clk);
        start = 1'b0;
        while (ndone == 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int d0, f0, e0;
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        for (int i = 0; i < 8; i++) wtab[i] = 16'h8001 ^ 16'(i * 16'h0F31);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 cs/sk/do", {29'd0, eep_cs, eep_sk, eep_do}, 32'd0);
        chk("R1 busy/done/err", {29'd0, busy, done, err}, 32'd0);
        chk("R1 valid/take", {30'd0, rd_valid, wr_take}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", {28'd0, busy, eep_cs, eep_sk, err}, 32'd0);

        // Table of read bursts.
        for (int t = 0; t < 6; t++) begin
            logic [7:0] m;
            m  = RTAB[t][16] ? 8'hFF : 8'h3F;
            d0 = desel;
            burst(1'b0, RTAB[t][16], RTAB[t][15:8], RTAB[t][7:0]);
            chk("R4 word count", 32'(nrd), 32'(RTAB[t][7:0]));
            for (int i = 0; i < int'(RTAB[t][7:0]); i++)
                chk("R3/R4/R6 read word", 32'(rd_got[i]),
                    32'(pat(int'((RTAB[t][15:8] + 8'(i)) & m))));
            chk("R5 one pulse per deselect", 32'(desel - d0), 32'(RTAB[t][7:0]));
            chk("R11 busy low after done", 32'(busy), 32'd0);
        end
        chk("R2 single select period", 32'(bad_lead), 32'd0);

        // Write burst, 6-bit address.
        d0 = desel;
        burst(1'b1, 1'b0, 8'd10, 8'd3);
        chk("R7 enable length 6-bit", 32'(ewen_len), 32'd9);
        chk("R7 disable length 6-bit", 32'(ewds_len), 32'd9);
        chk("R7 protected after burst", 32'(we), 32'd0);
        chk("R8 take count", 32'(ntake), 32'd3);
        for (int i = 0; i < 3; i++) chk("R8 written word", 32'(mem[10 + i]), 32'(wtab[i]));
        chk("R9 deselects in write", 32'(desel - d0), 32'd5);
        chk("R9 no error", 32'(err), 32'd0);
        burst(1'b0, 1'b0, 8'd10, 8'd3);
        for (int i = 0; i < 3; i++) chk("R8 read back", 32'(rd_got[i]), 32'(wtab[i]));

        // Write burst, 8-bit address.
        burst(1'b1, 1'b1, 8'd250, 8'd2);
        chk("R7 enable length 8-bit", 32'(ewen_len), 32'd11);
        chk("R7 disable length 8-bit", 32'(ewds_len), 32'd11);
        chk("R6 8-bit write address", 32'(mem[250]), 32'(wtab[0]));
        chk("R6 8-bit write address", 32'(mem[251]), 32'(wtab[1]));
        chk("R6 alias untouched", 32'(mem[58]), 32'(pat(58)));
        chk("R2 single select period", 32'(bad_lead), 32'd0);

        // Ready never comes: timeout.
        stuck = 1'b1;
        burst(1'b1, 1'b1, 8'd40, 8'd3);
        stuck = 1'b0;
        chk("R10 error set", 32'(err), 32'd1);
        chk("R10 remaining words skipped", 32'(ntake), 32'd1);
        chk("R10 disable still sent", 32'(we), 32'd0);
        chk("R10 later word untouched", 32'(mem[41]), 32'(pat(41)));
        chk("R10 done reached", 32'(ndone), 32'd1);

        // Zero count.
        f0 = frames; d0 = desel;
        burst(1'b0, 1'b1, 8'd3, 8'd0);
        chk("R12 no frames", 32'(frames - f0), 32'd0);
        chk("R12 no clock pulses", 32'(desel - d0), 32'd0);
        chk("R12 done pulse", 32'(ndone), 32'd1);
        chk("R10 error cleared by start", 32'(err), 32'd0);

        // Start while busy is ignored.
        e0 = ewen_cnt;
        @(negedge clk);
        wr_mode = 1'b0; addr8 = 1'b0; addr = 8'd20; count = 8'd2; start = 1'b1;
        nrd = 0; ndone = 0; aw_m = 6;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk("R11 busy mid-burst", 32'(busy), 32'd1);
        wr_mode = 1'b1; addr = 8'd0; count = 8'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (ndone == 0) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R11 second start ignored", 32'(nrd), 32'd2);
        chk("R11 no write started", 32'(ewen_cnt - e0), 32'd0);
        chk("R11 words intact", 32'(rd_got[1]), 32'(pat(21)));
        chk("R11 single done", 32'(ndone), 32'd1);
        chk("R13 high half length", 32'(sk_bad), 32'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule